// File: doc/BRIEF.md
# Protected Translation Lookaside Buffer

This block is a small, fully associative store of recently used page translations. Each request presents a virtual page number, a page offset, an access kind (load, store or instruction fetch) and a user/kernel mode bit. One cycle later the block answers with exactly one of three outcomes: a hit carrying the physical address, a miss, or a protection fault. Every resident entry is compared against the incoming page number at the same time. Each entry holds these fields:

- the virtual page tag
- the physical page number
- a two-bit rights field
- a kernel-only flag
- valid, dirty and reference bits

The block does not walk the page table. A miss tells an external handler to fetch the mapping and write it in through the fill port. The fill port chooses the slot by itself. When a fill displaces a live entry, the block reports the displaced page and whether it was written to, so that the page can be written back. A reference-clear command supports periodic sampling of page use for an approximate least-recently-used policy. A flush command empties the table when the address space changes.

Top module: `tlb_prot`

## Requirements
- R1: After reset no entry is valid, every response and eviction output is low, and any lookup misses.
- R2: A lookup accepted in cycle t is answered in cycle t+1 with `rsp_valid` high. On a hit, `rsp_paddr` is the entry's physical page number in the upper bits and the request offset, unchanged, in the lower `OFF_W` bits. On a miss or fault, `rsp_paddr` is zero.
- R3: When no valid entry matches the page number, exactly `rsp_miss` is raised and no entry state changes.
- R4: The rights field grants permissions as follows: bit 0 permits stores and bit 1 permits fetches, so 00 is read-only, 01 is read/write, 10 is read/execute and 11 is all. Loads (kind 0) are always permitted. A store (kind 1) to an entry with bit 0 clear, or a fetch (kind 2) from an entry with bit 1 clear, gives `rsp_fault` instead of a hit.
- R5: Any access in user mode (`req_user`=1) to an entry flagged kernel-only gives `rsp_fault`.
- R6: A store that hits marks its entry dirty. A fault does not mark the entry dirty. A fill that displaces the entry reports this on `evict_dirty`.
- R7: A hit sets the entry's reference bit; a fault or miss does not. `ref_clear` resets all reference bits in one cycle. A hit in the same cycle as `ref_clear` still sets its own bit.
- R8: A fill whose page number is already resident rewrites that entry in place. Otherwise the fill goes to the lowest-numbered invalid entry. When the table is full, the fill scans round-robin from the pointer. Entries with the reference bit set are skipped, and their bit is cleared as they are passed. The first entry with a clear bit is the victim, or the pointer's own entry if every bit was set. The pointer then moves to the slot after the victim. A displaced entry is reported one cycle later on `evict_valid`/`evict_vpn`. Every filled entry starts clean and unreferenced.
- R9: `flush` clears every valid, dirty and reference bit and resets the pointer to slot 0 in one cycle. A fill in the same cycle is dropped.
- R10: A lookup in the same cycle as a fill or flush is answered from the contents before that edge. A store hit on an entry displaced in that same cycle makes `evict_dirty` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset, passed through |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch (3 acts as load) |
| req_user | input | 1 | 1 when the access is made in user mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry refuses this access |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a hit |
| wr_en | input | 1 | Fill a translation |
| wr_vpn | input | VPN_W | Page number of the fill |
| wr_ppn | input | PPN_W | Physical page number of the fill |
| wr_rights | input | 2 | Rights field of the fill |
| wr_kern | input | 1 | Kernel-only flag of the fill |
| ref_clear | input | 1 | Clear all reference bits |
| flush | input | 1 | Invalidate the whole table |
| evict_valid | output | 1 | A fill displaced a live entry last cycle |
| evict_vpn | output | VPN_W | Page number of the displaced entry |
| evict_dirty | output | 1 | Displaced entry had been stored to |

## Verification
The hardest state to reach from the ports is a full table in which every reference bit is set, so that a fill has to pass the whole ring and fall back to the pointer's own slot. A close second is a full table in which only some bits survive a clear. The stimulus first fills all sixteen slots with distinct pages and touches each one. A fill of a new page then forces the full-ring pass. After that, the stimulus switches to long random traffic over a pool of page numbers slightly larger than the table, mixed with sparse reference clears and rare flushes. This keeps the table full and the reference bits in varied patterns. A behavioural model in the bench predicts every response and every eviction. The model also covers fills, hits and clears that land in the same cycle.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [1:0]             req_kind,
  input  logic                   req_user,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_fault,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  input  logic                   wr_en,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic [1:0]             wr_rights,
  input  logic                   wr_kern,
  input  logic                   ref_clear,
  input  logic                   flush,
  output logic                   evict_valid,
  output logic [VPN_W-1:0]       evict_vpn,
  output logic                   evict_dirty
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] K_STORE = 2'd1;
  localparam logic [1:0] K_FETCH = 2'd2;

  logic [N-1:0]       e_valid, e_dirty, e_ref, e_kern;
  logic [VPN_W-1:0]   e_vpn    [N];
  logic [PPN_W-1:0]   e_ppn    [N];
  logic [1:0]         e_rights [N];
  logic [IDX_W-1:0]   ptr;

  logic [N-1:0]       l_match, w_match;
  logic [IDX_W-1:0]   l_idx, w_idx, free_idx, vic, w_tgt;
  logic [N-1:0]       pass_mask;
  logic               l_any, l_ok, l_hit, l_store, w_any, free_any, w_do, w_evict;
  logic [1:0]         sel_rights;
  logic               sel_kern;
  logic [N-1:0]       ref_nxt, dirty_nxt, valid_nxt;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign l_match[g] = e_valid[g] && (e_vpn[g] == req_vpn);
    assign w_match[g] = e_valid[g] && (e_vpn[g] == wr_vpn);
  end

  assign l_any    = |l_match;
  assign w_any    = |w_match;
  assign free_any = ~&e_valid;

  always_comb begin
    l_idx = '0;
    w_idx = '0;
    free_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (l_match[i]) l_idx = IDX_W'(i);
      if (w_match[i]) w_idx = IDX_W'(i);
    end
    for (int i = N - 1; i >= 0; i--)
      if (!e_valid[i]) free_idx = IDX_W'(i);
  end

  assign sel_rights = e_rights[l_idx];
  assign sel_kern   = e_kern[l_idx];
  assign l_ok = !(req_user && sel_kern) &&
                !(req_kind == K_STORE && !sel_rights[0]) &&
                !(req_kind == K_FETCH && !sel_rights[1]);
  assign l_hit   = req_valid && l_any && l_ok;
  assign l_store = l_hit && (req_kind == K_STORE);

  always_comb begin
    logic             found;
    logic [IDX_W-1:0] idx;
    found     = 1'b0;
    vic       = ptr;
    pass_mask = '0;
    for (int k = 0; k < N; k++) begin
      idx = ptr + IDX_W'(k);
      if (!found) begin
        if (!e_ref[idx]) begin
          found = 1'b1;
          vic   = idx;
        end else begin
          pass_mask[idx] = 1'b1;
        end
      end
    end
  end

  assign w_do    = wr_en && !flush;
  assign w_evict = w_do && !w_any && !free_any;
  assign w_tgt   = w_any ? w_idx : (free_any ? free_idx : vic);

  always_comb begin
    ref_nxt   = e_ref;
    dirty_nxt = e_dirty;
    valid_nxt = e_valid;
    if (ref_clear) ref_nxt = '0;
    if (w_evict)   ref_nxt = ref_nxt & ~pass_mask;
    if (l_hit)     ref_nxt[l_idx] = 1'b1;
    if (l_store)   dirty_nxt[l_idx] = 1'b1;
    if (w_do) begin
      ref_nxt[w_tgt]   = 1'b0;
      dirty_nxt[w_tgt] = 1'b0;
      valid_nxt[w_tgt] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid     <= '0;
      e_dirty     <= '0;
      e_ref       <= '0;
      e_kern      <= '0;
      ptr         <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_dirty <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= l_hit;
      rsp_miss    <= req_valid && !l_any;
      rsp_fault   <= req_valid && l_any && !l_ok;
      rsp_paddr   <= l_hit ? {e_ppn[l_idx], req_off} : '0;
      evict_valid <= w_evict;
      evict_vpn   <= w_evict ? e_vpn[vic] : '0;
      evict_dirty <= w_evict && (e_dirty[vic] || (l_store && l_idx == vic));
      if (flush) begin
        e_valid <= '0;
        e_dirty <= '0;
        e_ref   <= '0;
        ptr     <= '0;
      end else begin
        e_valid <= valid_nxt;
        e_dirty <= dirty_nxt;
        e_ref   <= ref_nxt;
        if (w_do)    e_kern[w_tgt] <= wr_kern;
        if (w_evict) ptr <= vic + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_do) begin
      e_vpn[w_tgt]    <= wr_vpn;
      e_ppn[w_tgt]    <= wr_ppn;
      e_rights[w_tgt] <= wr_rights;
    end
  end

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));
  p_no_outcome_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
  p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_off)));
  p_store_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && l_any && req_kind == K_STORE && !e_rights[l_idx][0]) |=> rsp_fault);
  p_user_kernel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && l_any && req_user && e_kern[l_idx]) |=> rsp_fault);
  p_store_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_store && !flush && !(w_do && w_tgt == l_idx)) |=> e_dirty[$past(l_idx)]);
  p_evict_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> $past(&e_valid));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_valid == '0 && ptr == '0));
endmodule

// File: tb/tlb_prot_bench.sv
module tlb_prot_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, VPN_W = 20, PPN_W = 20, OFF_W = 12;
  localparam int CYCLES = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_user = 0, wr_en = 0, wr_kern = 0, ref_clear = 0, flush = 0;
  logic [VPN_W-1:0] req_vpn = '0, wr_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0] req_kind = '0, wr_rights = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, evict_valid, evict_dirty;
  logic [PPN_W+OFF_W-1:0] rsp_paddr;
  logic [VPN_W-1:0] evict_vpn;

  tlb_prot #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_tlb_prot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
    .req_kind(req_kind), .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .wr_en(wr_en),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_rights(wr_rights), .wr_kern(wr_kern),
    .ref_clear(ref_clear), .flush(flush), .evict_valid(evict_valid), .evict_vpn(evict_vpn),
    .evict_dirty(evict_dirty));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_valid[N], m_kern[N], m_dirty[N], m_ref[N];
  int m_vpn[N], m_ppn[N], m_rights[N];
  int m_ptr = 0;
  bit x_valid, x_hit, x_miss, x_fault, x_ev, x_evd;
  longint x_paddr;
  int x_evvpn;
  string x_tag = "R1";
  int since_flush = 100;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic model_step();
    int j, wi, fi, vi;
    bit ok, hit, st, vic_path, found;
    bit pass[N];
    j = -1; wi = -1; fi = -1; vi = m_ptr; found = 0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_vpn[i] == int'(req_vpn)) j = i;
      if (m_valid[i] && m_vpn[i] == int'(wr_vpn)) wi = i;
      pass[i] = 0;
    end
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) fi = i;
    for (int k = 0; k < N; k++) begin
      int idx = (m_ptr + k) % N;
      if (!found) begin
        if (!m_ref[idx]) begin found = 1; vi = idx; end
        else pass[idx] = 1;
      end
    end
    ok = 1;
    if (j >= 0) begin
      if (req_user && m_kern[j]) ok = 0;
      if (req_kind == 2'd1 && (m_rights[j] & 1) == 0) ok = 0;
      if (req_kind == 2'd2 && (m_rights[j] & 2) == 0) ok = 0;
    end
    hit = req_valid && j >= 0 && ok;
    st  = hit && req_kind == 2'd1;
    x_valid = req_valid;
    x_hit   = hit;
    x_miss  = req_valid && j < 0;
    x_fault = req_valid && j >= 0 && !ok;
    x_paddr = hit ? ((longint'(m_ppn[j]) << OFF_W) | longint'(req_off)) : 0;
    vic_path = wr_en && !flush && wi < 0 && fi < 0;
    x_ev    = vic_path;
    x_evvpn = vic_path ? m_vpn[vi] : 0;
    x_evd   = vic_path && (m_dirty[vi] || (st && j == vi));
    if (since_flush < 8 && req_valid) x_tag = "R9";
    else if (req_valid && (wr_en || flush)) x_tag = "R10";
    else if (req_valid && ref_clear) x_tag = "R7";
    else if (x_fault && req_user && m_kern[j]) x_tag = "R5";
    else if (x_fault) x_tag = "R4";
    else if (x_miss) x_tag = "R3";
    else x_tag = "R2";
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_ref[i] = 0; end
      m_ptr = 0;
      since_flush = 0;
    end else begin
      if (since_flush < 100) since_flush++;
      if (ref_clear) for (int i = 0; i < N; i++) m_ref[i] = 0;
      if (vic_path) for (int i = 0; i < N; i++) if (pass[i]) m_ref[i] = 0;
      if (hit) m_ref[j] = 1;
      if (st) m_dirty[j] = 1;
      if (wr_en) begin
        int t = (wi >= 0) ? wi : ((fi >= 0) ? fi : vi);
        m_valid[t] = 1; m_vpn[t] = int'(wr_vpn); m_ppn[t] = int'(wr_ppn);
        m_rights[t] = int'(wr_rights); m_kern[t] = wr_kern; m_dirty[t] = 0; m_ref[t] = 0;
        if (vic_path) m_ptr = (vi + 1) % N;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (rsp_valid !== x_valid || rsp_hit !== x_hit || rsp_miss !== x_miss ||
        rsp_fault !== x_fault || longint'(rsp_paddr) != x_paddr) begin
      fails++;
      $display("FAIL %s: rsp v/h/m/f/pa %b%b%b%b/%h expected %b%b%b%b/%h", x_tag,
               rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr,
               x_valid, x_hit, x_miss, x_fault, x_paddr);
    end
    if (x_ev || evict_valid) begin
      checks++;
      if (evict_valid !== x_ev || int'(evict_vpn) != x_evvpn) begin
        fails++;
        $display("FAIL R8 (R7 reference state): evict %b/%h expected %b/%h",
                 evict_valid, evict_vpn, x_ev, x_evvpn);
      end else if (evict_dirty !== x_evd) begin
        fails++;
        $display("FAIL R6: evict_dirty %b expected %b", evict_dirty, x_evd);
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      if (c == 0) x_tag = "R1";
      compare();
      req_valid = 0; wr_en = 0; ref_clear = 0; flush = 0; req_user = 0; req_kind = 2'd0;
      if (c == 0) begin
        req_valid = 1; req_vpn = 20'h00003; req_off = 12'h5a5;
      end else if (c <= 16) begin
        wr_en = 1; wr_vpn = 20'(32'h100 + c - 1); wr_ppn = 20'(32'h8000 + c);
        wr_rights = 2'd3; wr_kern = 0;
      end else if (c <= 32) begin
        req_valid = 1; req_vpn = 20'(32'h100 + c - 17); req_off = 12'(c * 37);
        req_kind = 2'd1;
      end else if (c == 33) begin
        wr_en = 1; wr_vpn = 20'h00999; wr_ppn = 20'h00777; wr_rights = 2'd0;
      end else if (c == 34) begin
        req_valid = 1; req_vpn = 20'h00100;
      end else begin
        if ($urandom_range(99) < 70) begin
          req_valid = 1;
          req_vpn  = 20'(32'h100 + $urandom_range(23));
          req_off  = 12'($urandom);
          req_kind = 2'($urandom_range(2));
          req_user = 1'($urandom_range(1));
        end
        if ($urandom_range(99) < 15) begin
          wr_en = 1;
          wr_vpn = 20'(32'h100 + $urandom_range(23));
          wr_ppn = 20'($urandom);
          wr_rights = 2'($urandom_range(3));
          wr_kern = ($urandom_range(3) == 0);
        end
        ref_clear = ($urandom_range(99) < 3);
        flush = ($urandom_range(999) < 5);
      end
      model_step();
    end
    @(negedge clk);
    compare();
    done = 1;
    summary();
    $finish;
  end
endmodule